// File: doc/BRIEF.md
# Block-Averaging Image Downscaler

This block shrinks a high-resolution 8-bit grey-level window to a small, fixed-size image. Each output pixel is the rounded mean of a rectangular cell of input pixels. The cell edges come from separate horizontal and vertical scale factors, given as unsigned 8.8 fixed-point numbers of input pixels per output pixel. A scale factor may have a fractional part. Every input pixel up to the last cell edge falls into exactly one cell. The outer edge of cell n is the integer part of n times the scale factor. When the fractional parts of these running edges fall inside a pixel, that pixel is not weighted or shared between neighbours, so no multiplies by fractions are needed per pixel. A run-time option, coarse resampling, lets only every other input line contribute. This roughly halves the input data used for a small loss of accuracy.

Pixels arrive in raster order on a valid/ready stream, with a start-of-frame flag on the first pixel and an end-of-line flag on the last pixel of every line. The scale factors and the coarse option are sampled while the start-of-frame pixel waits at the input. The cell edge tables are computed once at that point and held for the whole frame. One accumulator per output column collects the sums for the current band of lines. When the last line of a band ends, the row of means is sent out in column order on a second valid/ready stream.

Back-pressure: an output word stays on the pins with its flags unchanged until the sink takes it. While a row of means is being produced, `in_ready` is low, so the source is held off until the whole row has left. The block only accepts an input pixel on a cycle where `in_valid` and `in_ready` are both high.

Top module: `blkavg_downscaler`

## Requirements
- R1: With horizontal scale Wh (8.8 format, integer part at least 1), output column j (0-based) averages input columns floor(j·Wh)+1 through floor((j+1)·Wh), counted 1-based along the line.
- R2: With vertical scale Wv (8.8 format, integer part at least 1), output row i (0-based) averages input lines floor(i·Wv)+1 through floor((i+1)·Wv), counted 1-based from the start-of-frame pixel's line.
- R3: Each output equals (S + floor(N/2)) / N with integer division, where S is the sum and N the count of the contributing pixels of its cell. The result is exact for any 8-bit input.
- R4: Input columns after the last column cell edge, and lines after the last row cell edge, have no effect on any output.
- R5: With coarse mode set at start of frame, only odd-numbered lines (1-based) contribute to sums and counts. A cell with no contributing line outputs 0.
- R6: Each frame yields OUT_ROWS·OUT_COLS outputs in raster order. `out_eol` is high on the last column of each row, and `out_eof` is high only on the final output of the frame. Nothing further is emitted until the next frame.
- R7: While `out_valid` is high and `out_ready` is low, `out_data`, `out_eol` and `out_eof` hold their values. `in_ready` is low whenever `out_valid` is high.
- R8: Outside a frame, pixels without start-of-frame are accepted and dropped. A start-of-frame pixel arriving in the middle of a frame abandons the partial sums and starts a new frame with that pixel.
- R9: After reset, `out_valid` is low and `in_ready` is high when no start-of-frame pixel is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scale_h | input | SCALE_W | Horizontal input pixels per output pixel, 8.8 unsigned |
| scale_v | input | SCALE_W | Vertical input lines per output line, 8.8 unsigned |
| coarse_en | input | 1 | Use only odd lines of the frame |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the input pixel |
| in_data | input | PIX_W | Input grey level |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Averaged pixel present |
| out_ready | input | 1 | Sink takes the averaged pixel |
| out_data | output | PIX_W | Averaged grey level |
| out_eol | output | 1 | Last output of a row |
| out_eof | output | 1 | Last output of a frame |

## Verification
The hardest case to reach from the ports is a frame start arriving in the middle of a frame, after some partial sums have built up but before any row band has completed. The stimulus sends the first few pixels of a frame full of bright values, then starts a clean frame without ever closing a line. The outputs must then match the clean frame alone. Sink stalls driven by a pseudo-random ready pattern make sure held outputs and input blocking are seen in every frame. Frames with surplus columns and lines, and coarse frames whose cell heights give one or two contributing lines, cover the discard and line-skipping paths.

// File: rtl/blkavg_pkg.sv
package blkavg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_EMIT
  } blk_state_e;

  typedef enum logic [1:0] {
    PH_START,
    PH_WAIT,
    PH_SHOW
  } emit_ph_e;

endpackage

// File: rtl/scale_edges.sv
// Table of cell outer edges, integer part of (n+1)*scale, loaded once per frame.
module scale_edges #(
  parameter int SCALE_W = 16,
  parameter int FRAC_W  = 8,
  parameter int N       = 16,
  parameter int IDX_W   = $clog2(N + 1),
  parameter int POS_W   = SCALE_W - FRAC_W + IDX_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [SCALE_W-1:0]        scale,
  output logic [N-1:0][POS_W-1:0]   edges
);
  localparam int PROD_W = SCALE_W + IDX_W;

  for (genvar g = 0; g < N; g++) begin : g_edge
    logic [PROD_W-1:0] prod;
    assign prod = PROD_W'(scale) * PROD_W'(g + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        edges[g] <= '0;
      end else if (load) begin
        edges[g] <= prod[FRAC_W +: POS_W];
      end
    end
  end

endmodule

// File: rtl/cell_acc_bank.sv
// One running sum per output column.
module cell_acc_bank #(
  parameter int N     = 16,
  parameter int PIX_W = 8,
  parameter int ACC_W = 24,
  parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             add_en,
  input  logic [SEL_W-1:0] add_idx,
  input  logic [PIX_W-1:0] add_pix,
  input  logic             clr_en,
  input  logic [SEL_W-1:0] clr_idx,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [ACC_W-1:0] rd_sum
);
  logic [ACC_W-1:0] acc [N];

  assign rd_sum = acc[rd_idx];

  for (genvar g = 0; g < N; g++) begin : g_cell
    logic [ACC_W:0] wide_sum;
    assign wide_sum = {1'b0, acc[g]} + (ACC_W + 1)'(add_pix);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc[g] <= '0;
      end else if (clr_all || (clr_en && clr_idx == SEL_W'(g))) begin
        acc[g] <= '0;
      end else if (add_en && add_idx == SEL_W'(g)) begin
        acc[g] <= wide_sum[ACC_W-1:0];
      end
    end

    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (add_en && add_idx == SEL_W'(g) && !clr_all) |-> !wide_sum[ACC_W]); // R3
  end

endmodule

// File: rtl/rnd_div.sv
// Restoring divider, one quotient bit per cycle.
module rnd_div #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] den_q, rem_q;
  logic [NUM_W-1:0] q_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] diff;

  assign shifted = {rem_q, q_q[NUM_W-1]};
  assign diff    = {1'b0, shifted} - {2'b00, den_q};
  assign done    = done_q;
  assign quot    = q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q  <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      den_q  <= den;
      rem_q  <= '0;
      q_q    <= num;
      cnt_q  <= CNT_W'(NUM_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (!diff[DEN_W+1]) begin
        rem_q <= diff[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && den_q != '0) |-> (rem_q < den_q)); // R3

endmodule

// File: rtl/blkavg_downscaler.sv
module blkavg_downscaler
  import blkavg_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int OUT_COLS = 16,
  parameter int OUT_ROWS = 16,
  parameter int SCALE_W  = 16,
  parameter int FRAC_W   = 8,
  parameter int ACC_W    = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SCALE_W-1:0] scale_h,
  input  logic [SCALE_W-1:0] scale_v,
  input  logic               coarse_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PIX_W-1:0]   in_data,
  input  logic               in_sof,
  input  logic               in_eol,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PIX_W-1:0]   out_data,
  output logic               out_eol,
  output logic               out_eof
);
  localparam int CI_W   = $clog2(OUT_COLS + 1);
  localparam int RI_W   = $clog2(OUT_ROWS + 1);
  localparam int CSEL_W = (OUT_COLS > 1) ? $clog2(OUT_COLS) : 1;
  localparam int RSEL_W = (OUT_ROWS > 1) ? $clog2(OUT_ROWS) : 1;
  localparam int CPOS_W = SCALE_W - FRAC_W + CI_W;
  localparam int RPOS_W = SCALE_W - FRAC_W + RI_W;
  localparam int DEN_W  = CPOS_W + RPOS_W;
  localparam int NUM_W  = ACC_W + 1;

  blk_state_e state;
  emit_ph_e   ph;

  logic [CPOS_W-1:0] colpos, cpos;
  logic [RPOS_W-1:0] rowpos, rcnt;
  logic [CI_W-1:0]   jx, k;
  logic [RI_W-1:0]   iy;
  logic              fresh, coarse_q;
  logic [PIX_W-1:0]  pix_q;

  logic [OUT_COLS-1:0][CPOS_W-1:0] col_edges;
  logic [OUT_ROWS-1:0][RPOS_W-1:0] row_edges;

  logic              sof_hit, accept, jx_ok, row_use, row_last;
  logic [CSEL_W-1:0] csel, ksel;
  logic [RSEL_W-1:0] rsel;
  logic [CPOS_W-1:0] col_edge_cur, k_hi, k_lo, k_width;
  logic [RPOS_W-1:0] row_edge_cur;
  logic [DEN_W-1:0]  den;
  logic [NUM_W-1:0]  num;
  logic [ACC_W-1:0]  acc_rd;
  logic              div_done;
  logic [NUM_W-1:0]  div_quot;
  logic              k_last;

  // ---------------- edge tables, loaded once per frame ----------------
  scale_edges #(
    .SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .N(OUT_COLS), .IDX_W(CI_W), .POS_W(CPOS_W)
  ) u_col_edges (
    .clk(clk), .rst_n(rst_n), .load(state == ST_LOAD), .scale(scale_h), .edges(col_edges)
  );

  scale_edges #(
    .SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .N(OUT_ROWS), .IDX_W(RI_W), .POS_W(RPOS_W)
  ) u_row_edges (
    .clk(clk), .rst_n(rst_n), .load(state == ST_LOAD), .scale(scale_v), .edges(row_edges)
  );

  // ---------------- input side decode ----------------
  assign sof_hit = in_valid && in_sof;

  always_comb begin
    case (state)
      ST_IDLE: in_ready = !sof_hit;
      ST_RUN:  in_ready = !(sof_hit && !fresh);
      default: in_ready = 1'b0;
    endcase
  end

  assign accept       = in_valid && in_ready && (state == ST_RUN);
  assign jx_ok        = (jx < CI_W'(OUT_COLS));
  assign csel         = jx_ok ? jx[CSEL_W-1:0] : '0;
  assign col_edge_cur = col_edges[csel];
  assign cpos         = colpos + 1'b1;
  assign rsel         = iy[RSEL_W-1:0];
  assign row_edge_cur = row_edges[rsel];
  assign row_use      = !coarse_q || !rowpos[0];
  assign row_last     = ((rowpos + 1'b1) == row_edge_cur);

  // ---------------- emission side decode ----------------
  assign ksel    = k[CSEL_W-1:0];
  assign k_hi    = col_edges[ksel];
  assign k_lo    = (k == '0) ? '0 : col_edges[ksel - 1'b1];
  assign k_width = k_hi - k_lo;
  assign den     = DEN_W'(k_width) * DEN_W'(rcnt);
  assign num     = NUM_W'(acc_rd) + NUM_W'(den >> 1);
  assign k_last  = (k == CI_W'(OUT_COLS - 1));

  cell_acc_bank #(
    .N(OUT_COLS), .PIX_W(PIX_W), .ACC_W(ACC_W), .SEL_W(CSEL_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n),
    .clr_all(state == ST_LOAD),
    .add_en(accept && jx_ok && row_use),
    .add_idx(csel),
    .add_pix(in_data),
    .clr_en(out_valid && out_ready),
    .clr_idx(ksel),
    .rd_idx(ksel),
    .rd_sum(acc_rd)
  );

  rnd_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n),
    .start(state == ST_EMIT && ph == PH_START),
    .num(num), .den(den),
    .done(div_done), .quot(div_quot)
  );

  // ---------------- control ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ph       <= PH_START;
      colpos   <= '0;
      rowpos   <= '0;
      rcnt     <= '0;
      jx       <= '0;
      iy       <= '0;
      k        <= '0;
      fresh    <= 1'b0;
      coarse_q <= 1'b0;
      pix_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sof_hit) state <= ST_LOAD;
        end
        ST_LOAD: begin
          coarse_q <= coarse_en;
          colpos   <= '0;
          rowpos   <= '0;
          rcnt     <= '0;
          jx       <= '0;
          iy       <= '0;
          k        <= '0;
          fresh    <= 1'b1;
          state    <= ST_RUN;
        end
        ST_RUN: begin
          if (sof_hit && !fresh) begin
            state <= ST_LOAD;
          end else if (accept) begin
            fresh  <= 1'b0;
            colpos <= cpos;
            if (jx_ok && cpos == col_edge_cur) jx <= jx + 1'b1;
            if (in_eol) begin
              colpos <= '0;
              jx     <= '0;
              rowpos <= rowpos + 1'b1;
              if (row_use) rcnt <= rcnt + 1'b1;
              if (row_last) begin
                state <= ST_EMIT;
                ph    <= PH_START;
                k     <= '0;
              end
            end
          end
        end
        ST_EMIT: begin
          case (ph)
            PH_START: ph <= PH_WAIT;
            PH_WAIT: begin
              if (div_done) begin
                pix_q <= (den == '0) ? '0 : div_quot[PIX_W-1:0];
                ph    <= PH_SHOW;
              end
            end
            default: begin
              if (out_ready) begin
                ph <= PH_START;
                if (k_last) begin
                  k    <= '0;
                  rcnt <= '0;
                  iy   <= iy + 1'b1;
                  state <= (iy == RI_W'(OUT_ROWS - 1)) ? ST_IDLE : ST_RUN;
                end else begin
                  k <= k + 1'b1;
                end
              end
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = (state == ST_EMIT) && (ph == PH_SHOW);
  assign out_data  = pix_q;
  assign out_eol   = out_valid && k_last;
  assign out_eof   = out_eol && (iy == RI_W'(OUT_ROWS - 1));

  // ---------------- assertions ----------------
  AST_SCALE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |-> (scale_h >= SCALE_W'(1 << FRAC_W) && scale_v >= SCALE_W'(1 << FRAC_W))); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eol) && $stable(out_eof))); // R7

  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R7

  AST_MEAN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (div_done && den != '0) |-> ((div_quot >> PIX_W) == '0)); // R3

  AST_EOF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eof) |=> !out_valid); // R6

endmodule

// File: tb/sim_blkavg_downscaler.sv
module sim_blkavg_downscaler;
  localparam int OC = 4;
  localparam int OR = 3;
  localparam int NOUT = OC * OR;

  typedef struct packed {
    logic [15:0] wh;
    logic [15:0] wv;
    logic        coarse;
    logic [3:0]  xc;
    logic [3:0]  xr;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'h0200, 16'h0200, 1'b0, 4'd0, 4'd0, 8'd1},
    '{16'h0280, 16'h01C0, 1'b0, 4'd3, 4'd2, 8'd7},
    '{16'h0340, 16'h0280, 1'b1, 4'd1, 4'd1, 8'd19},
    '{16'h0100, 16'h0100, 1'b0, 4'd0, 4'd0, 8'd200},
    '{16'h05E6, 16'h0466, 1'b1, 4'd2, 4'd3, 8'd55}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] scale_h = 16'h0100, scale_v = 16'h0100;
  logic        coarse_en = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_eol, out_eof;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  int tests = 0;
  int fails = 0;
  logic [7:0] got_d [NOUT];
  logic       got_l [NOUT];
  logic       got_f [NOUT];
  logic [7:0] rlfsr = 8'hA5;

  always #5 clk = ~clk;

  blkavg_downscaler #(.OUT_COLS(OC), .OUT_ROWS(OR)) u0 (
    .clk(clk), .rst_n(rst_n), .scale_h(scale_h), .scale_v(scale_v), .coarse_en(coarse_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_eol(out_eol), .out_eof(out_eof)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pv(input int r, input int c, input int s);
    int t;
    t = r * 53 + c * 29 + s * 71 + ((r * c) % 17) * 5;
    return t[7:0];
  endfunction

  function automatic int exp_px(input int i, input int j, input vec_t v);
    int c0, c1, r0, r1, sum, n;
    c0 = (j * int'(v.wh)) >> 8;
    c1 = ((j + 1) * int'(v.wh)) >> 8;
    r0 = (i * int'(v.wv)) >> 8;
    r1 = ((i + 1) * int'(v.wv)) >> 8;
    sum = 0;
    n = 0;
    for (int r = r0 + 1; r <= r1; r++) begin
      if (!v.coarse || (r % 2 == 1)) begin
        for (int c = c0 + 1; c <= c1; c++) begin
          sum += int'(pv(r - 1, c - 1, int'(v.seed)));
          n++;
        end
      end
    end
    return (n == 0) ? 0 : (sum + n / 2) / n;
  endfunction

  task automatic push(input logic [7:0] d, input logic s, input logic e);
    in_valid = 1'b1;
    in_data  = d;
    in_sof   = s;
    in_eol   = e;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        @(posedge clk);
        break;
      end
    end
    #1;
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eol   = 1'b0;
  endtask

  task automatic send_frame(input vec_t v);
    int w, h;
    w = ((OC * int'(v.wh)) >> 8) + int'(v.xc);
    h = ((OR * int'(v.wv)) >> 8) + int'(v.xr);
    scale_h   = v.wh;
    scale_v   = v.wv;
    coarse_en = v.coarse;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        push(pv(r, c, int'(v.seed)), (r == 0 && c == 0), (c == w - 1));
  endtask

  task automatic collect();
    int n;
    logic stalled;
    logic [7:0] held;
    n = 0;
    stalled = 1'b0;
    held = '0;
    while (n < NOUT) begin
      @(negedge clk);
      if (out_valid) begin
        chk(!in_ready, "R7 in_ready low while output pending", int'(in_ready), 0);
        if (stalled) chk(out_data == held, "R7 held data under stall", int'(out_data), int'(held));
        if (out_ready) begin
          got_d[n] = out_data;
          got_l[n] = out_eol;
          got_f[n] = out_eof;
          n++;
        end
      end
      stalled = out_valid && !out_ready;
      held = out_data;
      @(posedge clk);
      #1;
      rlfsr = {rlfsr[6:0], rlfsr[7] ^ rlfsr[5] ^ rlfsr[4] ^ rlfsr[3]};
      out_ready = rlfsr[0] | rlfsr[3];
    end
    out_ready = 1'b0;
  endtask

  task automatic check_frame(input vec_t v, input string tag);
    int e;
    for (int i = 0; i < OR; i++) begin
      for (int j = 0; j < OC; j++) begin
        e = exp_px(i, j, v);
        chk(got_d[i * OC + j] == e[7:0], tag, int'(got_d[i * OC + j]), e);
        chk(got_l[i * OC + j] == (j == OC - 1), "R6 out_eol position",
            int'(got_l[i * OC + j]), int'(j == OC - 1));
        chk(got_f[i * OC + j] == (i == OR - 1 && j == OC - 1), "R6 out_eof position",
            int'(got_f[i * OC + j]), int'(i == OR - 1 && j == OC - 1));
      end
    end
  endtask

  task automatic quiet(input int cyc, input string tag);
    logic seen;
    seen = 1'b0;
    for (int t = 0; t < cyc; t++) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
    chk(!seen, tag, int'(seen), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    vec_t clean;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);

    // R8: pixels outside a frame are consumed and produce nothing
    for (int p = 0; p < 6; p++) begin
      in_valid = 1'b1;
      in_data  = 8'd255;
      in_eol   = (p % 3 == 2);
      @(negedge clk);
      chk(in_ready == 1'b1, "R8 idle pixel accepted", int'(in_ready), 1);
    end
    in_valid = 1'b0;
    in_eol   = 1'b0;
    quiet(60, "R8 no output from idle pixels");

    // table-driven frames: R1 R2 R3 R4 R5 R6
    for (int vi = 0; vi < 5; vi++) begin
      fork
        send_frame(VECS[vi]);
        collect();
      join
      check_frame(VECS[vi], $sformatf("R1 R2 R3 R4 R5 mean vector %0d", vi));
      quiet(80, "R4 R6 nothing after frame end");
    end

    // R8: restart mid-frame after bright partial data
    scale_h = 16'h0280;
    scale_v = 16'h01C0;
    coarse_en = 1'b0;
    for (int p = 0; p < 4; p++) push(8'd255, (p == 0), 1'b0);
    clean = '{16'h0280, 16'h01C0, 1'b0, 4'd1, 4'd0, 8'd3};
    fork
      send_frame(clean);
      collect();
    join
    check_frame(clean, "R8 restart discards partial sums");

    // R3: flat bright image keeps the top level exactly
    clean = '{16'h0180, 16'h0140, 1'b0, 4'd0, 4'd0, 8'd0};
    scale_h = clean.wh;
    scale_v = clean.wv;
    fork
      begin
        for (int r = 0; r < 3 * 5 / 4; r++)
          for (int c = 0; c < 6; c++) push(8'd255, (r == 0 && c == 0), (c == 5));
      end
      collect();
    join
    for (int q = 0; q < NOUT; q++)
      chk(got_d[q] == 8'd255, "R3 flat 255 image", int'(got_d[q]), 255);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule